// File: doc/BRIEF.md
# Random-Number Engine Command and Interrupt Controller

This block is the register-level control front end of a random-number engine. Software drives it through a 32-bit register port in which every write takes effect at the clock edge that samples it and every read is answered combinationally within the same cycle. A write to the command register starts an engine operation. The controller tracks whether a generator state has been instantiated and refuses commands whose order is not legal. Each accepted operation holds a busy flag for a fixed number of cycles. A generate command fills four 32-bit result words.

Completion, noise-ready, self-test-complete, zeroize-done and alarm events are captured in a sticky status register whose bits software clears by writing ones. A single interrupt line combines these bits under a per-event mask and a global enable. In this block the physical entropy source, the deterministic generator cipher and the health tests are replaced by a xorshift stand-in and a busy counter. Every output is therefore predictable.

Top module: `rng_cmd_ctrl`

## Requirements
- R1: After reset, every readable register (status, interrupt status, alarm, interrupt enable, mode, secure-mode, result words) reads 0 and `irq` is low.
- R2: The register offsets are as follows. Command is at 0x00 (code in bits 3:0). Mode is at 0x04, with bits 4:0 read/write. Secure-mode is at 0x08, with bits 9:0 read/write: bit 1 is secure enable and bits 9:2 are the reject limit. Status is at 0x0C, interrupt enable at 0x10, interrupt status at 0x14 and alarm at 0x18. The result words are at 0x24, 0x28, 0x2C and 0x30. Unused bits and unmapped offsets read 0.
- R3: An accepted command other than no-op holds status bit 31 (busy) high for exactly BUSY_CYCLES cycles. When busy drops, interrupt-status bit 4 (done) is set.
- R4: Status bits 3:0 hold the code of the last accepted command. Status bit 7 is set when a create-state command (code 3) finishes.
- R5: Renew state (4), generate random (6) and advance state (7) issued while status bit 7 is clear do not run: busy stays low, status is unchanged, and alarm bit 4 and interrupt-status bit 3 are set.
- R6: Codes 9 to 14 never run. They set alarm bit 4 and interrupt-status bit 3.
- R7: Writing 1 to alarm bit 4 clears it. Alarm bits 3:0 (failed-test id) always read 0.
- R8: A command-register write while busy is ignored: no alarm, no change of status, and the operation already running completes normally.
- R9: A generate-random command (6) that finishes loads the result words from a 32-bit xorshift state x. The state starts at SEED after reset and is advanced by x^=x<<13, x^=x>>17, x^=x<<5. Word i receives the state after i+1 steps, and the state keeps the fourth value.
- R10: A generate-noise command (1) that finishes sets interrupt-status bit 2. A known-answer-test command (8) that finishes sets bit 1.
- R11: Interrupt-status bits are sticky. Writing 1 to a bit clears it, and a set event in the same cycle wins.
- R12: `irq` is high exactly when interrupt-enable bit 31 is set and some bit in 4:0 is set in both interrupt enable and interrupt status.
- R13: A zeroize command (15) that finishes clears status bit 7 and all result words, and sets interrupt-status bit 0.
- R14: A no-op (code 0) written while idle sets status bits 3:0 to 0 without raising busy or any interrupt-status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. Busy and the last-command code can therefore be read back one cycle later, and an illegal-order alarm appears in that same cycle. Done and the per-command event bits, the state flag and the result words change at the edge that ends the busy window. That edge comes exactly BUSY_CYCLES edges after the accepting one. The bench drives at falling edges and reads the combinational read port half a cycle later. It counts the number of falling edges on which busy is seen and checks the count against BUSY_CYCLES. Only after that does it compare status, event bits and words with a bench-side model of the command order and the xorshift sequence.

// File: rtl/rngc_pkg.sv
package rngc_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int EV_W   = 5;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_SMODE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IST   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_ALRM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_OUT   = 8'h24;

    localparam int EV_ZERO = 0;
    localparam int EV_KAT  = 1;
    localparam int EV_NOIS = 2;
    localparam int EV_ALRM = 3;
    localparam int EV_DONE = 4;

    localparam int ALRM_SEQ_BIT = 4;
    localparam int IEN_GLBL_BIT = 31;

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_NOISE  = 4'd1,
        OP_NONCE  = 4'd2,
        OP_CREATE = 4'd3,
        OP_RENEW  = 4'd4,
        OP_ADDIN  = 4'd5,
        OP_GEN    = 4'd6,
        OP_ADV    = 4'd7,
        OP_KAT    = 4'd8,
        OP_WIPE   = 4'd15
    } op_e;

    typedef struct packed {
        logic       glbl;
        logic [EV_W-1:0] ev;
    } ien_t;

    function automatic logic op_known(input logic [3:0] c);
        return (c <= 4'd8) || (c == 4'd15);
    endfunction

    function automatic logic op_needs_state(input logic [3:0] c);
        return (c == OP_RENEW) || (c == OP_GEN) || (c == OP_ADV);
    endfunction

    function automatic logic [DATA_W-1:0] xs_step(input logic [DATA_W-1:0] x);
        logic [DATA_W-1:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

endpackage

// File: rtl/rngc_seq.sv
module rngc_seq
    import rngc_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [3:0] cmd_code,
    output logic       busy,
    output logic [3:0] last_cmd,
    output logic [3:0] run_cmd,
    output logic       state_valid,
    output logic       fin,
    output logic       bad_seq
);

    localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign fin     = busy && (cnt == '0);
    assign bad_seq = cmd_wr && !busy &&
                     (!op_known(cmd_code) || (op_needs_state(cmd_code) && !state_valid));
    assign accept  = cmd_wr && !busy && !bad_seq;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            cnt         <= '0;
            last_cmd    <= 4'd0;
            run_cmd     <= 4'd0;
            state_valid <= 1'b0;
        end else if (fin) begin
            busy <= 1'b0;
            if (run_cmd == OP_CREATE) state_valid <= 1'b1;
            if (run_cmd == OP_WIPE)   state_valid <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end else if (accept) begin
            last_cmd <= cmd_code;
            if (cmd_code != OP_IDLE) begin
                busy    <= 1'b1;
                cnt     <= CNT_LOAD;
                run_cmd <= cmd_code;
            end
        end
    end

endmodule

// File: rtl/rngc_gen.sv
module rngc_gen
    import rngc_pkg::*;
#(
    parameter int                 N_OUT = 4,
    parameter logic [DATA_W-1:0]  SEED  = 32'h2545F491
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         fill,
    input  logic                         wipe,
    output logic [N_OUT-1:0][DATA_W-1:0] words
);

    logic [DATA_W-1:0]               src;
    logic [N_OUT:0][DATA_W-1:0]      chain;

    assign chain[0] = src;

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_step
            assign chain[g+1] = xs_step(chain[g]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            src   <= SEED;
            words <= '0;
        end else if (wipe) begin
            words <= '0;
        end else if (fill) begin
            src <= chain[N_OUT];
            for (int i = 0; i < N_OUT; i++) begin
                words[i] <= chain[i+1];
            end
        end
    end

endmodule

// File: rtl/rngc_irq.sv
module rngc_irq
    import rngc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_W-1:0] ev_set,
    input  logic            clr_wr,
    input  logic [EV_W-1:0] clr_mask,
    input  ien_t            ien,
    output logic [EV_W-1:0] istat,
    output logic            irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            istat <= '0;
        end else begin
            for (int i = 0; i < EV_W; i++) begin
                if (ev_set[i])
                    istat[i] <= 1'b1;
                else if (clr_wr && clr_mask[i])
                    istat[i] <= 1'b0;
            end
        end
    end

    assign irq = ien.glbl && |(ien.ev & istat);

endmodule

// File: rtl/rng_cmd_ctrl.sv
module rng_cmd_ctrl
    import rngc_pkg::*;
#(
    parameter int                BUSY_CYCLES = 8,
    parameter int                N_OUT       = 4,
    parameter logic [DATA_W-1:0] SEED        = 32'h2545F491
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int MODE_W  = 5;
    localparam int SMODE_W = 10;
    localparam int OUT_END = int'(OFS_OUT) + 4 * N_OUT;

    logic                         busy;
    logic [3:0]                   last_cmd;
    logic [3:0]                   run_cmd;
    logic                         state_valid;
    logic                         fin;
    logic                         bad_seq;
    logic [N_OUT-1:0][DATA_W-1:0] out_words;
    logic [EV_W-1:0]              istat;
    logic [EV_W-1:0]              ev_set;
    logic [MODE_W-1:0]            mode_q;
    logic [SMODE_W-1:0]           smode_q;
    ien_t                         ien_q;
    logic                         alarm_ill;

    logic wr_cmd, wr_mode, wr_smode, wr_ien, wr_ist, wr_alrm;

    assign wr_cmd   = wr_en && (addr == OFS_CMD);
    assign wr_mode  = wr_en && (addr == OFS_MODE);
    assign wr_smode = wr_en && (addr == OFS_SMODE);
    assign wr_ien   = wr_en && (addr == OFS_IEN);
    assign wr_ist   = wr_en && (addr == OFS_IST);
    assign wr_alrm  = wr_en && (addr == OFS_ALRM);

    rngc_seq #(
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (wr_cmd),
        .cmd_code   (wdata[3:0]),
        .busy       (busy),
        .last_cmd   (last_cmd),
        .run_cmd    (run_cmd),
        .state_valid(state_valid),
        .fin        (fin),
        .bad_seq    (bad_seq)
    );

    rngc_gen #(
        .N_OUT(N_OUT),
        .SEED (SEED)
    ) u_gen (
        .clk  (clk),
        .rst  (rst),
        .fill (fin && (run_cmd == OP_GEN)),
        .wipe (fin && (run_cmd == OP_WIPE)),
        .words(out_words)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[EV_DONE] = fin;
        ev_set[EV_NOIS] = fin && (run_cmd == OP_NOISE);
        ev_set[EV_KAT]  = fin && (run_cmd == OP_KAT);
        ev_set[EV_ZERO] = fin && (run_cmd == OP_WIPE);
        ev_set[EV_ALRM] = bad_seq;
    end

    rngc_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev_set  (ev_set),
        .clr_wr  (wr_ist),
        .clr_mask(wdata[EV_W-1:0]),
        .ien     (ien_q),
        .istat   (istat),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            smode_q   <= '0;
            ien_q     <= '0;
            alarm_ill <= 1'b0;
        end else begin
            if (wr_mode)  mode_q  <= wdata[MODE_W-1:0];
            if (wr_smode) smode_q <= wdata[SMODE_W-1:0];
            if (wr_ien) begin
                ien_q.glbl <= wdata[IEN_GLBL_BIT];
                ien_q.ev   <= wdata[EV_W-1:0];
            end
            if (bad_seq)
                alarm_ill <= 1'b1;
            else if (wr_alrm && wdata[ALRM_SEQ_BIT])
                alarm_ill <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE:  rdata[MODE_W-1:0]  = mode_q;
            OFS_SMODE: rdata[SMODE_W-1:0] = smode_q;
            OFS_STAT:  rdata = {busy, 23'd0, state_valid, 3'd0, last_cmd};
            OFS_IEN:   rdata = {ien_q.glbl, {(DATA_W-1-EV_W){1'b0}}, ien_q.ev};
            OFS_IST:   rdata[EV_W-1:0] = istat;
            OFS_ALRM:  rdata[ALRM_SEQ_BIT] = alarm_ill;
            default: begin
                for (int i = 0; i < N_OUT; i++) begin
                    if (int'(addr) == int'(OFS_OUT) + 4 * i && int'(addr) < OUT_END)
                        rdata = out_words[i];
                end
            end
        endcase
    end

endmodule

// File: rtl/rngc_chk.sv
module rngc_chk
    import rngc_pkg::*;
#(
    parameter int N_OUT = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic                         busy,
    input logic [3:0]                   last_cmd,
    input logic                         state_valid,
    input logic [EV_W-1:0]              istat,
    input logic                         alarm_ill,
    input logic                         ien_glbl,
    input logic                         irq,
    input logic [N_OUT-1:0][DATA_W-1:0] words
);

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (addr == OFS_CMD);

    p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> $stable(last_cmd));

    p_no_state_no_run_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !busy && !state_valid && wdata[3:0] == 4'd6)
            |=> (alarm_ill && !busy && istat[EV_ALRM]));

    p_done_on_finish_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> istat[EV_DONE]);

    p_wipe_clears_r13: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && last_cmd == 4'd15)
            |-> (!state_valid && words == '0 && istat[EV_ZERO]));

    p_irq_needs_glbl_r12: assert property (@(posedge clk) disable iff (rst)
        !ien_glbl |-> !irq);

    p_nop_stays_idle_r14: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !busy && wdata[3:0] == 4'd0) |=> !busy);

endmodule

bind rng_cmd_ctrl rngc_chk #(.N_OUT(N_OUT)) u_rngc_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .busy       (busy),
    .last_cmd   (last_cmd),
    .state_valid(state_valid),
    .istat      (istat),
    .alarm_ill  (alarm_ill),
    .ien_glbl   (ien_q.glbl),
    .irq        (irq),
    .words      (out_words)
);

// File: tb/test_rng_cmd_ctrl.sv
module test_rng_cmd_ctrl;

    localparam int          BUSY = 8;
    localparam logic [31:0] SEED = 32'h2545F491;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 0;

    logic [31:0] m_src;
    logic [31:0] m_words [4];
    logic        m_st;
    logic [3:0]  m_last;

    always #2 clk = ~clk;

    rng_cmd_ctrl #(.BUSY_CYCLES(BUSY), .N_OUT(4), .SEED(SEED)) i_rng_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [31:0] xs(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [31:0] exp_stat(input logic st, input logic [3:0] last);
        return {24'd0, st, 3'd0, last};
    endfunction

    function automatic bit known(input logic [3:0] c);
        return (c <= 4'd8) || (c == 4'd15);
    endfunction

    function automatic bit needs_st(input logic [3:0] c);
        return (c == 4'd4) || (c == 4'd6) || (c == 4'd7);
    endfunction

    function automatic logic [4:0] exp_events(input logic [3:0] c);
        logic [4:0] e;
        e = 5'b10000;
        if (c == 4'd1)  e[2] = 1'b1;
        if (c == 4'd8)  e[1] = 1'b1;
        if (c == 4'd15) e[0] = 1'b1;
        return e;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_idle(output int cycles);
        logic [31:0] s;
        cycles = 0;
        rd(8'h0C, s);
        while (s[31] && cycles < 1000) begin
            cycles++;
            @(negedge clk);
            rd(8'h0C, s);
        end
    endtask

    task automatic model_apply(input logic [3:0] c);
        m_last = c;
        if (c == 4'd3) m_st = 1'b1;
        if (c == 4'd15) begin
            m_st = 1'b0;
            for (int i = 0; i < 4; i++) m_words[i] = 32'd0;
        end
        if (c == 4'd6) begin
            for (int i = 0; i < 4; i++) begin
                m_src = xs(m_src);
                m_words[i] = m_src;
            end
        end
    endtask

    task automatic check_words(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            rd(8'h24 + 8'(4 * i), v);
            chk(tag, v, m_words[i]);
        end
    endtask

    task automatic run_cmd(input logic [3:0] c, input string tag);
        logic [31:0] v;
        int cyc;
        wr(8'h00, {28'd0, c});
        if (!known(c) || (needs_st(c) && !m_st)) begin
            rd(8'h0C, v); chk({tag, " R5/R6 status"}, v, exp_stat(m_st, m_last));
            rd(8'h18, v); chk({tag, " R6 alarm"}, v, 32'h10);
            rd(8'h14, v); chk({tag, " R5 istat"}, v, 32'h08);
            wr(8'h18, 32'h10);
            rd(8'h18, v); chk({tag, " R7 alarm clear"}, v, 32'h0);
        end else if (c == 4'd0) begin
            model_apply(c);
            rd(8'h0C, v); chk({tag, " R14 status"}, v, exp_stat(m_st, m_last));
            rd(8'h14, v); chk({tag, " R14 istat"}, v, 32'h0);
        end else begin
            wait_idle(cyc);
            chk({tag, " R3 busy length"}, 32'(cyc), 32'(BUSY));
            model_apply(c);
            rd(8'h0C, v); chk({tag, " R4 status"}, v, exp_stat(m_st, m_last));
            rd(8'h14, v); chk({tag, " R10 istat"}, v, {27'd0, exp_events(c)});
            check_words({tag, " R9 words"});
        end
        wr(8'h14, 32'h1F);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int cyc;
        logic [3:0] pool [11];
        pool = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd15, 4'd11};
        m_src = SEED; m_st = 1'b0; m_last = 4'd0;
        for (int i = 0; i < 4; i++) m_words[i] = 32'd0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(8'h0C, v); chk("R1 status", v, 32'h0);
        rd(8'h14, v); chk("R1 istat", v, 32'h0);
        rd(8'h18, v); chk("R1 alarm", v, 32'h0);
        rd(8'h10, v); chk("R1 ien", v, 32'h0);
        check_words("R1 words");
        chk("R1 irq", {31'd0, irq}, 32'h0);

        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R2 smode mask", v, 32'h3FF);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R2 mode mask", v, 32'h1F);
        rd(8'h40, v); chk("R2 unmapped", v, 32'h0);

        run_cmd(4'd6, "dir gen-no-state");
        run_cmd(4'd12, "dir undefined");
        run_cmd(4'd3, "dir create");
        run_cmd(4'd6, "dir gen");

        // R8: second write during busy must be ignored
        wr(8'h00, 32'd1);
        wr(8'h00, 32'd15);
        wait_idle(cyc);
        model_apply(4'd1);
        rd(8'h0C, v); chk("R8 status", v, exp_stat(m_st, m_last));
        rd(8'h18, v); chk("R8 alarm", v, 32'h0);
        rd(8'h14, v); chk("R8 istat", v, 32'h14);
        check_words("R8 words kept");

        // R12: irq gating; R11: write-one-to-clear
        wr(8'h10, 32'h0000_0010);
        chk("R12 irq no global", {31'd0, irq}, 32'h0);
        wr(8'h10, 32'h8000_0010);
        chk("R12 irq global", {31'd0, irq}, 32'h1);
        wr(8'h14, 32'h10);
        rd(8'h14, v); chk("R11 partial clear", v, 32'h04);
        chk("R12 irq masked bit", {31'd0, irq}, 32'h0);
        wr(8'h14, 32'h1F);
        wr(8'h10, 32'h0);

        run_cmd(4'd8, "dir kat");
        run_cmd(4'd0, "dir nop");
        run_cmd(4'd15, "dir zeroize R13");
        run_cmd(4'd7, "dir advance-no-state");

        v = $urandom(32'd4242);
        for (int it = 0; it < 60; it++) begin
            run_cmd(pool[$urandom_range(0, 10)], "rnd");
        end

        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule